// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block routes the product-term clusters of one logic block onto its macrocell inputs. It takes sixteen clusters of five product terms each. Every cluster can be sent to its own macrocell or to one of three neighbours. Each macrocell ORs together all clusters sent to it, then passes the sum through an XOR. The XOR's second input is either the spare product term of the macrocell's own cluster or a programmable constant. Each cluster's spare term can instead be merged into the cluster's OR, which gives an extended cluster.

The shape of a cluster is set by the mode of its home macrocell, that is, the macrocell with the same index. This holds even when the cluster is steered elsewhere. A synchronous home uses four basic terms. An asynchronous home uses three basic terms and hands the fourth to a per-macrocell control output.

Configuration is written one word per cluster through a registered port and can be read back. A write that would steer a cluster outside its legal window is refused. The data path from product terms to outputs is purely combinational, and its delay is the same in every configuration. A parameter `SPLIT` selects a variant in which no cluster crosses the middle of the array.

Top module: `pt_steer_alloc`

## Requirements
- R1: After reset every configuration word reads 0 and `cfg_error` is low. A zero word means: steer to the home macrocell, spare term not extended, polarity 0, synchronous mode. With all words zero, `sop_out[n]` is (OR of terms 0..3 of cluster n) XOR term 4 of cluster n. Term t of cluster n is `pt_in[n*5+t]`.
- R2: Configuration word bits [1:0] are the steering code. Code 0 sends cluster n to macrocell n, 1 to n+1, 2 to n-1 and 3 to n-2.
- R3: `sop_out[m]` is the OR of the contributions of every cluster whose stored steering targets macrocell m, XORed with that macrocell's XOR input.
- R4: A write whose target lies below macrocell 0 or above the last macrocell is rejected.
- R5: With `SPLIT`=1, a write whose target lies in the other half of the array (macrocells 0..7 versus 8..15) is also rejected. With `SPLIT`=0 the same write is accepted.
- R6: A rejected write leaves every configuration word unchanged and sets `cfg_error`. The flag stays set through later legal writes until reset. Legal writes are stored and take effect from the clock edge that samples `cfg_we`.
- R7: Word bit 2 (extend) set adds term 4 of the cluster to the OR that the cluster delivers to its target.
- R8: The XOR input of macrocell n is term 4 of cluster n when word n has extend clear and steering code 0. Otherwise it is word n bit 3 (polarity).
- R9: Word bit 4 (mode) of word n, when set (asynchronous), limits cluster n's basic contribution to terms 0..2 and drives term 3 onto `async_ctl[n]`. This applies wherever cluster n is steered. When the bit is clear, terms 0..3 contribute and `async_ctl[n]` is 0.
- R10: `cfg_rdata` shows the stored word selected by `cfg_idx`, with no clock delay.
- R11: `sop_out` and `async_ctl` follow `pt_in` combinationally, within the same cycle, in every configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Cluster index for write and read-back |
| cfg_wdata | input | 5 | Word to write: {mode, polarity, extend, steer[1:0]} |
| cfg_rdata | output | 5 | Stored word of cluster `cfg_idx` |
| cfg_error | output | 1 | Sticky flag for a rejected write |
| pt_in | input | 80 | Product terms, five per cluster |
| sop_out | output | 16 | Sum-of-products per macrocell, after the XOR |
| async_ctl | output | 16 | Control term per macrocell in asynchronous mode |

## Verification
There are two kinds of result. A configuration write is due one clock edge after `cfg_we` is sampled. At that point the new `cfg_rdata`, `cfg_error` and the steering shown on `sop_out` all appear together. `sop_out`, `async_ctl` and `cfg_rdata` otherwise respond with zero cycles of delay to `pt_in` and `cfg_idx`.

The bench therefore drives every input on the falling edge. After a write, it samples at the next falling edge, which is half a period after the capturing rising edge. After a change to product terms or read index alone, it samples one nanosecond later with no clock edge in between. The `SPLIT`=0 and `SPLIT`=1 instances share stimulus, so one write checks both acceptance and rejection of the same boundary-crossing steer.

// File: rtl/pt_alloc_pkg.sv
package pt_alloc_pkg;

   localparam int PT_PER_CL = 5;
   localparam int CFG_W     = 5;

   typedef struct packed {
      logic       mode;
      logic       pol;
      logic       ext;
      logic [1:0] steer;
   } cfg_word_t;

   function automatic int steer_off(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 1;
         2'd2:    return -1;
         default: return -2;
      endcase
   endfunction

   function automatic logic [1:0] code_for_off(input int off);
      case (off)
         1:       return 2'd1;
         -1:      return 2'd2;
         -2:      return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic steer_legal(input int home, input logic [1:0] code,
                                        input int ncl, input bit split);
      int tgt;
      int half;
      tgt  = home + steer_off(code);
      half = ncl / 2;
      if (tgt < 0 || tgt >= ncl) return 1'b0;
      if (split && ((tgt / half) != (home / half))) return 1'b0;
      return 1'b1;
   endfunction

endpackage

// File: rtl/pt_cfg_store.sv
module pt_cfg_store
   import pt_alloc_pkg::*;
#(
   parameter int NUM_CL = 16,
   parameter bit SPLIT  = 1'b0,
   localparam int IDX_W = $clog2(NUM_CL)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        idx,
   input  logic [CFG_W-1:0]        wdata,
   output logic [CFG_W-1:0]        rdata,
   output logic                    err,
   output logic [NUM_CL*CFG_W-1:0] words_flat
);

   cfg_word_t words [NUM_CL];
   cfg_word_t wword;
   logic      wr_legal;
   logic      all_legal;

   assign wword    = cfg_word_t'(wdata);
   assign wr_legal = steer_legal(int'(idx), wword.steer, NUM_CL, SPLIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CL; i++) words[i] <= '0;
         err <= 1'b0;
      end else if (we) begin
         if (wr_legal) words[idx] <= wword;
         else          err        <= 1'b1;
      end
   end

   assign rdata = words[idx];

   always_comb begin
      all_legal = 1'b1;
      for (int i = 0; i < NUM_CL; i++) begin
         words_flat[i*CFG_W +: CFG_W] = words[i];
         if (!steer_legal(i, words[i].steer, NUM_CL, SPLIT)) all_legal = 1'b0;
      end
   end

   // R6: refused write changes no word
   p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wr_legal) |=> ($stable(words_flat) && err));

   // R6: error flag is sticky
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R2: accepted write lands in the addressed word
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_legal) |=> (words[$past(idx)] == $past(wword)));

   // R4/R5: no stored steer ever leaves its window
   p_window_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      all_legal);

endmodule

// File: rtl/pt_cluster_shape.sv
module pt_cluster_shape
   import pt_alloc_pkg::*;
(
   input  logic [PT_PER_CL-1:0] pt,
   input  cfg_word_t            cfg,
   output logic                 val,
   output logic                 xor_src,
   output logic                 ctl
);

   logic basic;

   always_comb begin
      basic   = cfg.mode ? (|pt[2:0]) : (|pt[3:0]);
      val     = basic | (cfg.ext & pt[4]);
      ctl     = cfg.mode & pt[3];
      xor_src = (!cfg.ext && cfg.steer == 2'd0) ? pt[4] : cfg.pol;
   end

endmodule

// File: rtl/pt_mc_combine.sv
module pt_mc_combine
   import pt_alloc_pkg::*;
#(
   parameter int NUM_CL = 16,
   parameter bit SPLIT  = 1'b0,
   parameter int MC_IDX = 0
) (
   input  logic [NUM_CL-1:0]   cl_val,
   input  logic [2*NUM_CL-1:0] cl_steer,
   input  logic                xor_in,
   output logic                sop
);

   localparam int HALF = NUM_CL / 2;

   logic [3:0] hit;

   for (genvar d = 0; d < 4; d++) begin : g_win
      localparam int C = MC_IDX - 1 + d;
      if (C >= 0 && C < NUM_CL && (!SPLIT || (C / HALF) == (MC_IDX / HALF))) begin : g_in
         assign hit[d] = cl_val[C] &&
                         (cl_steer[2*C +: 2] == code_for_off(MC_IDX - C));
      end else begin : g_out
         assign hit[d] = 1'b0;
      end
   end

   assign sop = (|hit) ^ xor_in;

endmodule

// File: rtl/pt_steer_alloc.sv
module pt_steer_alloc
   import pt_alloc_pkg::*;
#(
   parameter int NUM_CL = 16,
   parameter bit SPLIT  = 1'b0,
   localparam int IDX_W = $clog2(NUM_CL),
   localparam int PT_W  = NUM_CL * PT_PER_CL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic              cfg_error,
   input  logic [PT_W-1:0]   pt_in,
   output logic [NUM_CL-1:0] sop_out,
   output logic [NUM_CL-1:0] async_ctl
);

   if (NUM_CL < 4 || (NUM_CL % 2) != 0) begin : g_bad_ncl
      $error("NUM_CL must be even and at least 4");
   end
   if (SPLIT && NUM_CL < 8) begin : g_bad_split
      $error("SPLIT needs NUM_CL of at least 8");
   end

   logic [NUM_CL*CFG_W-1:0] cfg_flat;
   logic [NUM_CL-1:0]       cl_val;
   logic [NUM_CL-1:0]       xor_src;
   logic [2*NUM_CL-1:0]     cl_steer;

   pt_cfg_store #(.NUM_CL(NUM_CL), .SPLIT(SPLIT)) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .idx        (cfg_idx),
      .wdata      (cfg_wdata),
      .rdata      (cfg_rdata),
      .err        (cfg_error),
      .words_flat (cfg_flat)
   );

   for (genvar n = 0; n < NUM_CL; n++) begin : g_cl
      cfg_word_t w;
      assign w = cfg_word_t'(cfg_flat[n*CFG_W +: CFG_W]);
      assign cl_steer[2*n +: 2] = w.steer;

      pt_cluster_shape shape_i (
         .pt      (pt_in[n*PT_PER_CL +: PT_PER_CL]),
         .cfg     (w),
         .val     (cl_val[n]),
         .xor_src (xor_src[n]),
         .ctl     (async_ctl[n])
      );

      pt_mc_combine #(.NUM_CL(NUM_CL), .SPLIT(SPLIT), .MC_IDX(n)) mc_i (
         .cl_val   (cl_val),
         .cl_steer (cl_steer),
         .xor_in   (xor_src[n]),
         .sop      (sop_out[n])
      );
   end

   // R11: nothing but inputs and configuration moves the outputs
   p_comb_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(pt_in) && $stable(cfg_flat)) |-> ($stable(sop_out) && $stable(async_ctl)));

   // R9: control term is zero whenever its cluster's terms are all zero
   p_ctl_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_in == '0) |-> (async_ctl == '0));

endmodule

// File: tb/pt_steer_alloc_tb_top.sv
module pt_steer_alloc_tb_top;

   localparam int NCL = 16;
   localparam int PTW = NCL * 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [3:0]      cfg_idx = '0;
   logic [4:0]      cfg_wdata = '0;
   logic [PTW-1:0]  pt_in = '0;
   logic [4:0]      rd0, rd1;
   logic            er0, er1;
   logic [NCL-1:0]  sop0, sop1, ctl0, ctl1;

   int checks = 0;
   int fails  = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;
   bit [4:0] mcfg [2][NCL];
   bit       merr [2];

   always #2.5 clk = ~clk;

   pt_steer_alloc #(.NUM_CL(NCL), .SPLIT(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .cfg_error(er0),
      .pt_in(pt_in), .sop_out(sop0), .async_ctl(ctl0));

   pt_steer_alloc #(.NUM_CL(NCL), .SPLIT(1'b1)) dut_split_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .cfg_error(er1),
      .pt_in(pt_in), .sop_out(sop1), .async_ctl(ctl1));

   function automatic int off_of(input bit [1:0] c);
      return (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? -1 : -2;
   endfunction

   function automatic bit legal(input int k, input int idx, input bit [1:0] c);
      int t = idx + off_of(c);
      if (t < 0 || t > NCL - 1) return 1'b0;
      if (k == 1 && ((t < 8) != (idx < 8))) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit [NCL-1:0] exp_sop(input int k);
      bit [NCL-1:0] r = '0;
      for (int c = 0; c < NCL; c++) begin
         bit [4:0] w = mcfg[k][c];
         bit v = w[4] ? |pt_in[c*5 +: 3] : |pt_in[c*5 +: 4];
         if (w[2]) v = v | pt_in[c*5+4];
         if (v) r[c + off_of(w[1:0])] = 1'b1;
      end
      for (int m = 0; m < NCL; m++) begin
         bit [4:0] w = mcfg[k][m];
         r[m] = r[m] ^ ((!w[2] && w[1:0] == 0) ? pt_in[m*5+4] : w[3]);
      end
      return r;
   endfunction

   function automatic bit [NCL-1:0] exp_ctl(input int k);
      bit [NCL-1:0] r;
      for (int c = 0; c < NCL; c++) r[c] = mcfg[k][c][4] & pt_in[c*5+3];
      return r;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_outs(input string tag);
      chk(tag, "sop0", 32'(sop0), 32'(exp_sop(0)));
      chk(tag, "sop1", 32'(sop1), 32'(exp_sop(1)));
      chk(tag, "ctl0", 32'(ctl0), 32'(exp_ctl(0)));
      chk(tag, "ctl1", 32'(ctl1), 32'(exp_ctl(1)));
      chk(tag, "err0", 32'(er0), 32'(merr[0]));
      chk(tag, "err1", 32'(er1), 32'(merr[1]));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 2; k++) begin
         merr[k] = 1'b0;
         for (int c = 0; c < NCL; c++) mcfg[k][c] = '0;
      end
   endtask

   task automatic wr(input int idx, input bit [4:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
      for (int k = 0; k < 2; k++) begin
         if (legal(k, idx, d[1:0])) mcfg[k][idx] = d;
         else merr[k] = 1'b1;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic new_pt();
      for (int i = 0; i < 3; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         pt_in[i*32 +: 32] = lfsr;
      end
   endtask

   task automatic rand_sweep(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         new_pt();
         #1;
         check_outs(tag);
      end
   endtask

   task automatic t_reset_r1();
      do_reset();
      #1;
      for (int i = 0; i < NCL; i++) begin
         cfg_idx = 4'(i);
         #1;
         chk("R1", "rdata0", 32'(rd0), 0);
         chk("R1", "rdata1", 32'(rd1), 0);
      end
      chk("R1", "err0", 32'(er0), 0);
      pt_in = '0; pt_in[3*5+2] = 1'b1; pt_in[3*5+4] = 1'b1; pt_in[9*5+4] = 1'b1;
      #1;
      chk("R1", "sop xor", 32'(sop0), 32'h0000_0200);
      rand_sweep("R1", 6);
   endtask

   task automatic t_steer_r2();
      do_reset();
      for (int code = 0; code < 4; code++) begin
         wr(5, 5'(code) | 5'b01000);
         pt_in = '0; pt_in[5*5+0] = 1'b1;
         #1;
         chk("R2", "target", 32'(sop0 & ~16'h0020), 32'(16'h1 << (5 + off_of(2'(code)))) & ~32'h0020);
         check_outs("R2");
      end
   endtask

   task automatic t_or_r3();
      do_reset();
      wr(4, 5'b00001);
      wr(6, 5'b00010);
      wr(7, 5'b00011);
      pt_in = '0; pt_in[7*5+1] = 1'b1;
      #1;
      chk("R3", "M5 from C7", 32'(sop0[5]), 1);
      rand_sweep("R3", 8);
   endtask

   task automatic t_edges_r4();
      do_reset();
      wr(0, 5'b00010);
      chk("R4", "C0 down err", 32'(er0), 1);
      cfg_idx = 0; #1;
      chk("R4", "C0 kept", 32'(rd0), 0);
      do_reset();
      wr(15, 5'b00001);
      chk("R4", "C15 up err", 32'(er0), 1);
      do_reset();
      wr(1, 5'b00011);
      chk("R4", "C1 n-2 err", 32'(er0), 1);
      wr(1, 5'b00010);
      cfg_idx = 1; #1;
      chk("R4", "C1 n-1 ok", 32'(rd0), 32'h2);
      rand_sweep("R4", 4);
   endtask

   task automatic t_split_r5();
      do_reset();
      wr(7, 5'b00001);
      chk("R5", "nosplit ok", 32'(er0), 0);
      chk("R5", "split err", 32'(er1), 1);
      cfg_idx = 7; #1;
      chk("R5", "split kept", 32'(rd1), 0);
      chk("R5", "nosplit stored", 32'(rd0), 1);
      wr(8, 5'b00010);
      wr(9, 5'b00011);
      wr(6, 5'b00001);
      chk("R5", "C6 to M7 split ok", 32'(mcfg[1][6]), 1);
      rand_sweep("R5", 6);
   endtask

   task automatic t_sticky_r6();
      do_reset();
      wr(3, 5'b01001);
      wr(15, 5'b00001);
      wr(3, 5'b00010);
      chk("R6", "sticky", 32'(er0), 1);
      cfg_idx = 3; #1;
      chk("R6", "later write ok", 32'(rd0), 32'h2);
      do_reset();
      #1;
      chk("R6", "cleared", 32'(er0), 0);
   endtask

   task automatic t_extend_r7();
      do_reset();
      wr(10, 5'b00101);
      pt_in = '0; pt_in[10*5+4] = 1'b1;
      #1;
      chk("R7", "extra joins", 32'(sop0), 32'h0000_0800);
      rand_sweep("R7", 4);
   endtask

   task automatic t_xor_r8();
      do_reset();
      wr(2, 5'b01100);
      pt_in = '0; pt_in[2*5+4] = 1'b1;
      #1;
      chk("R8", "ext pol", 32'(sop0[2]), 0);
      wr(2, 5'b01010);
      pt_in = '0;
      #1;
      chk("R8", "routed pol", 32'(sop0[2]), 1);
      wr(2, 5'b01000);
      pt_in[2*5+4] = 1'b1;
      #1;
      chk("R8", "term4 xor", 32'(sop0[2]), 1);
      rand_sweep("R8", 4);
   endtask

   task automatic t_mode_r9();
      do_reset();
      wr(6, 5'b10001);
      pt_in = '0; pt_in[6*5+3] = 1'b1;
      #1;
      chk("R9", "ctl6", 32'(ctl0), 32'h0040);
      chk("R9", "no sum", 32'(sop0), 0);
      pt_in[6*5+2] = 1'b1;
      #1;
      chk("R9", "M7 gets C6", 32'(sop0), 32'h0080);
      wr(7, 5'b00000);
      pt_in = '0; pt_in[7*5+3] = 1'b1;
      #1;
      chk("R9", "sync no ctl", 32'(ctl0), 0);
      chk("R9", "sync term3", 32'(sop0), 32'h0080);
      rand_sweep("R9", 6);
   endtask

   task automatic t_readback_r10();
      do_reset();
      wr(12, 5'b11010);
      wr(13, 5'b10101);
      cfg_idx = 12; #1;
      chk("R10", "rd12", 32'(rd0), 32'h1A);
      cfg_idx = 13; #1;
      chk("R10", "rd13", 32'(rd0), 32'h15);
   endtask

   task automatic t_comb_r11();
      do_reset();
      wr(4, 5'b00110);
      wr(9, 5'b11011);
      wr(11, 5'b01101);
      rand_sweep("R11", 10);
   endtask

   initial begin
      fork
         begin
            t_reset_r1();
            t_steer_r2();
            t_or_r3();
            t_edges_r4();
            t_split_r5();
            t_sticky_r6();
            t_extend_r7();
            t_xor_r8();
            t_mode_r9();
            t_readback_r10();
            t_comb_r11();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule